// File: doc/BRIEF.md
# Daisy-Chain Driver Address Assignment

This block is the per-device logic that lets a chain of identical display drivers number themselves in order. The devices share one oscillator clock and a three-wire bus: a shared address clock, a chain input coming from the previous device and a chain output going to the next. The device whose chain input is held high while reset is applied becomes the master. It divides the oscillator down to produce the address clock burst. Every other device only receives that clock.

During a configuration pass each device counts address-clock rising edges while its chain input is low. It freezes that count as its own address at the first rising edge that finds the chain input high. On the next falling edge of the address clock it raises its chain output, which hands the token to the next device. A pass runs once after reset and again whenever the one-cycle configuration trigger fires. A trigger that arrives during a pass starts the pass over.

Outside a pass, the chain output is reused as an active-low interrupt. When automatic plane changing is enabled, each plane-change event pulls it low for a fixed number of oscillator cycles.

Top module: `chain_addr_node`

## Requirements
- R1: The device whose `chain_in` is high on the first clock after reset is released becomes the master and raises `aclk_oe`. Every other device keeps `aclk_oe` low. During reset `aclk_oe`, `chain_out` and `addr_valid` are all low.
- R2: While a pass is running, consecutive rising edges of the master's `aclk_out` are exactly DIV (4) oscillator cycles apart. The clock is high for two of those cycles and low for two.
- R3: Each pass produces exactly NDEV (256) rising edges on `aclk_out`. After that the address clock stays low.
- R4: `chain_out` goes low on the clock edge that starts a pass. It goes high 4*N+6 oscillator cycles later (N + 1.5 address-clock periods), where N is the device's address.
- R5: After a pass, the device at position N in the chain (the master is position 0) holds `addr` = N.
- R6: `addr_valid` is low for the whole of a pass. It goes high when the burst ends, provided the device captured an address.
- R7: A pass runs once automatically after reset, with no trigger. A one-cycle `cfg_start` pulse runs another pass.
- R8: A `cfg_start` pulse during a pass restarts it. Addresses and `chain_out` timing then follow R4 and R5, measured from the latest trigger, and the new burst again has 256 rising edges.
- R9: When `auto_en` is high, `plane_evt` is pulsed, no pass is running and the address is valid, `chain_out` goes low for exactly 512 oscillator cycles and then returns high.
- R10: `plane_evt` has no effect on `chain_out` when `auto_en` is low or while a pass is running.
- R11: `owns_global` is high only on a device that holds a valid address of 0. That is the master alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_start | input | 1 | One-cycle pulse that starts (or restarts) a configuration pass |
| auto_en | input | 1 | Automatic plane changing enabled |
| plane_evt | input | 1 | One-cycle automatic plane-change event |
| chain_in | input | 1 | Token input from the previous device (tied high on the master) |
| aclk_in | input | 1 | Address clock as seen on the shared wire |
| aclk_out | output | 1 | Address clock generated by this device |
| aclk_oe | output | 1 | Output enable for `aclk_out` (master only) |
| chain_out | output | 1 | Token output to the next device; active-low interrupt when idle |
| addr | output | 8 | Captured device address |
| addr_valid | output | 1 | Address captured and pass finished |
| owns_global | output | 1 | This device answers global register reads |

## Verification
The bench builds a six-device chain and watches every chain output against the shared address clock. It times each token hand-off in oscillator cycles, so an off-by-one in edge counting or a hand-off made on the wrong clock edge gives a wrong address or a hand-off late or early by a half period. It counts the edges and gaps of the burst, which catches a burst one edge too long or short, or a wrong divide ratio. It fires a second trigger in the middle of a pass, so a design that fails to clear its count on restart ends up with stale addresses. It also times the interrupt pulse to the cycle, and sends plane events with automatic mode off and during a pass, where a wrongly gated design would pull the chain low.

// File: rtl/chain_addr_pkg.sv
package chain_addr_pkg;

  // Level of the address clock at pass-cycle pc: low for a lead-in of
  // div-1 cycles, then high for div/2 and low for div/2 in each period.
  function automatic logic aclk_level(input int unsigned pc, input int unsigned div);
    if (pc < div - 1) return 1'b0;
    return ((pc - (div - 1)) % div) < (div / 2);
  endfunction

  // Number of pass cycles for a burst of n address-clock periods.
  function automatic int unsigned pass_cycles(input int unsigned n, input int unsigned div);
    return (div - 1) + div * n;
  endfunction

  // Oscillator cycles from pass start to the rise of chain_out at address a.
  function automatic int unsigned handoff_delay(input int unsigned a, input int unsigned div);
    return div * a + div + div / 2;
  endfunction

endpackage

// File: rtl/chain_pass_seq.sv
module chain_pass_seq
  import chain_addr_pkg::*;
#(
  parameter int DIV  = 4,
  parameter int NDEV = 256,
  parameter int PCW  = $clog2(pass_cycles(NDEV, DIV))
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  output logic           busy,
  output logic           done,
  output logic           aclk_gen,
  output logic [PCW-1:0] pc
);
  localparam int LAST = pass_cycles(NDEV, DIV) - 1;
  localparam int RCW  = $clog2(NDEV + 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      pc   <= '0;
    end else if (start) begin
      busy <= 1'b1;
      pc   <= '0;
    end else if (busy) begin
      if (pc == PCW'(LAST)) busy <= 1'b0;
      else                  pc   <= pc + 1'b1;
    end
  end

  assign done     = busy && (pc == PCW'(LAST));
  assign aclk_gen = busy && aclk_level(32'(pc), DIV);

  // checker: rising edges produced in the current pass
  logic           gen_q;
  logic [RCW-1:0] rise_chk;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_q    <= 1'b0;
      rise_chk <= '0;
    end else begin
      gen_q <= aclk_gen;
      if (start)                  rise_chk <= '0;
      else if (aclk_gen && !gen_q) rise_chk <= rise_chk + 1'b1;
    end
  end

  p_burst_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rise_chk == RCW'(NDEV)));
  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !aclk_gen);
endmodule

// File: rtl/chain_addr_cap.sv
module chain_addr_cap #(
  parameter int NDEV = 256,
  parameter int AW   = $clog2(NDEV)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          busy,
  input  logic          done,
  input  logic          aclk_in,
  input  logic          chain_in,
  output logic [AW-1:0] addr,
  output logic          latched,
  output logic          addr_valid,
  output logic          aclk_fall
);
  logic aclk_q;
  logic aclk_rise;

  assign aclk_rise = aclk_in && !aclk_q;
  assign aclk_fall = !aclk_in && aclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aclk_q     <= 1'b0;
      addr       <= '0;
      latched    <= 1'b0;
      addr_valid <= 1'b0;
    end else begin
      aclk_q <= aclk_in;
      if (start) begin
        addr       <= '0;
        latched    <= 1'b0;
        addr_valid <= 1'b0;
      end else if (busy) begin
        if (aclk_rise && !latched) begin
          if (chain_in)                    latched <= 1'b1;
          else if (addr != AW'(NDEV - 1))  addr    <= addr + 1'b1;
        end
        if (done) addr_valid <= latched;
      end
    end
  end

  p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && latched && !start) |=> (addr == $past(addr)));
  p_valid_off_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !addr_valid);
endmodule

// File: rtl/chain_out_ctl.sv
module chain_out_ctl #(
  parameter int IRQ_LEN = 512,
  parameter int ICW     = $clog2(IRQ_LEN)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic busy,
  input  logic latched,
  input  logic aclk_fall,
  input  logic addr_valid,
  input  logic auto_en,
  input  logic plane_evt,
  output logic chain_out,
  output logic irq_active
);
  logic [ICW-1:0] irq_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_out  <= 1'b0;
      irq_active <= 1'b0;
      irq_cnt    <= '0;
    end else if (start) begin
      chain_out  <= 1'b0;
      irq_active <= 1'b0;
      irq_cnt    <= '0;
    end else if (busy) begin
      if (latched && aclk_fall) chain_out <= 1'b1;
    end else if (irq_active) begin
      if (irq_cnt == ICW'(IRQ_LEN - 1)) begin
        irq_active <= 1'b0;
        chain_out  <= 1'b1;
      end else begin
        irq_cnt <= irq_cnt + 1'b1;
      end
    end else if (auto_en && plane_evt && addr_valid) begin
      irq_active <= 1'b1;
      irq_cnt    <= '0;
      chain_out  <= 1'b0;
    end
  end

  p_low_at_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !chain_out);
  p_token_needs_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && chain_out) |-> latched);
  p_irq_drives_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_active |-> !chain_out);
  p_irq_not_in_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_active |-> !busy);
endmodule

// File: rtl/chain_addr_node.sv
module chain_addr_node
  import chain_addr_pkg::*;
#(
  parameter int NDEV    = 256,
  parameter int DIV     = 4,
  parameter int IRQ_LEN = 512,
  parameter int AW      = $clog2(NDEV)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_start,
  input  logic          auto_en,
  input  logic          plane_evt,
  input  logic          chain_in,
  input  logic          aclk_in,
  output logic          aclk_out,
  output logic          aclk_oe,
  output logic          chain_out,
  output logic [AW-1:0] addr,
  output logic          addr_valid,
  output logic          owns_global
);
  localparam int PCW = $clog2(pass_cycles(NDEV, DIV));

  logic           boot_pend;
  logic           is_master;
  logic           start;
  logic           busy;
  logic           done;
  logic           aclk_gen;
  logic [PCW-1:0] pc;
  logic           latched;
  logic           aclk_fall;
  logic           irq_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_pend <= 1'b1;
      is_master <= 1'b0;
    end else if (boot_pend) begin
      boot_pend <= 1'b0;
      is_master <= chain_in;
    end
  end

  assign start       = cfg_start || boot_pend;
  assign aclk_oe     = is_master;
  assign aclk_out    = aclk_gen;
  assign owns_global = addr_valid && (addr == '0);

  chain_pass_seq #(.DIV(DIV), .NDEV(NDEV), .PCW(PCW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .busy(busy), .done(done), .aclk_gen(aclk_gen), .pc(pc)
  );

  chain_addr_cap #(.NDEV(NDEV), .AW(AW)) u_cap (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .aclk_in(aclk_in), .chain_in(chain_in), .addr(addr),
    .latched(latched), .addr_valid(addr_valid), .aclk_fall(aclk_fall)
  );

  chain_out_ctl #(.IRQ_LEN(IRQ_LEN)) u_out (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .latched(latched), .aclk_fall(aclk_fall), .addr_valid(addr_valid),
    .auto_en(auto_en), .plane_evt(plane_evt),
    .chain_out(chain_out), .irq_active(irq_active)
  );

  p_owner_is_master_r11: assert property (@(posedge clk) disable iff (!rst_n)
    owns_global |-> is_master);
  p_master_fixed_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!boot_pend && !$past(boot_pend)) |-> $stable(is_master));
endmodule

// File: tb/sim_chain_addr_node.sv
module sim_chain_addr_node;
  localparam int NODES = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_start = 1'b0;
  logic auto_en = 1'b0;
  logic plane_evt = 1'b0;

  logic [NODES-1:0] co, vl, oe, og, ao;
  logic [7:0]       ad [NODES];
  logic             bus;

  int nchk = 0, nfail = 0;
  int cyc = 0;
  int fall_t [NODES];
  int rise_t [NODES];
  int low_cnt = 0;
  int aclk_rises = 0, gap_bad = 0, last_rise = -1;
  logic [NODES-1:0] co_p = '0;
  logic bus_p = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign bus = oe[0] ? ao[0] : 1'b0;

  chain_addr_node u0 (
    .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .auto_en(auto_en),
    .plane_evt(plane_evt), .chain_in(1'b1), .aclk_in(bus), .aclk_out(ao[0]),
    .aclk_oe(oe[0]), .chain_out(co[0]), .addr(ad[0]), .addr_valid(vl[0]),
    .owns_global(og[0])
  );

  for (genvar k = 1; k < NODES; k++) begin : g_node
    chain_addr_node u_n (
      .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .auto_en(auto_en),
      .plane_evt(plane_evt), .chain_in(co[k-1]), .aclk_in(bus), .aclk_out(ao[k]),
      .aclk_oe(oe[k]), .chain_out(co[k]), .addr(ad[k]), .addr_valid(vl[k]),
      .owns_global(og[k])
    );
  end

  always @(negedge clk) begin
    for (int k = 0; k < NODES; k++) begin
      if (co_p[k] && !co[k]) fall_t[k] = cyc;
      if (!co_p[k] && co[k]) rise_t[k] = cyc;
    end
    if (co != {NODES{1'b1}}) low_cnt++;
    if (bus && !bus_p) begin
      if (last_rise >= 0 && cyc - last_rise != 4) gap_bad++;
      last_rise = cyc;
      aclk_rises++;
    end
    co_p  = co;
    bus_p = bus;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clr_mon();
    @(negedge clk);
    aclk_rises = 0; gap_bad = 0; last_rise = -1; low_cnt = 0;
  endtask

  task automatic pulse_cfg();
    @(negedge clk) cfg_start = 1'b1;
    @(negedge clk) cfg_start = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_addrs(input string req);
    for (int k = 0; k < NODES; k++) begin
      chk(ad[k] == 8'(k), req, ad[k], k);
      chk(vl[k] == 1'b1, req, vl[k], 1);
    end
  endtask

  task automatic t_reset();
    wait_cyc(3);
    chk(co == '0, "R1 chain_out in reset", co, 0);
    chk(vl == '0, "R1 addr_valid in reset", vl, 0);
    chk(oe == '0, "R1 aclk_oe in reset", oe, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_boot();
    wait_cyc(1100);
    chk(oe == 6'b000001, "R1 only master drives clock", oe, 1);
    chk(aclk_rises == 256, "R7 boot pass burst", aclk_rises, 256);
    chk(gap_bad == 0, "R2 clock period", gap_bad, 0);
    chk(og == 6'b000001, "R11 global owner", og, 1);
    check_addrs("R5 boot addresses");
  endtask

  task automatic t_trigger();
    clr_mon();
    pulse_cfg();
    wait_cyc(500);
    chk(vl == '0, "R6 valid low mid-pass", vl, 0);
    wait_cyc(600);
    chk(vl == {NODES{1'b1}}, "R6 valid after burst", vl, 63);
    chk(aclk_rises == 256, "R3 burst length", aclk_rises, 256);
    chk(gap_bad == 0, "R2 clock period", gap_bad, 0);
    for (int k = 0; k < NODES; k++)
      chk(rise_t[k] - fall_t[k] == 4 * k + 6, "R4 hand-off delay",
          rise_t[k] - fall_t[k], 4 * k + 6);
    check_addrs("R5 addresses");
    clr_mon();
    wait_cyc(100);
    chk(aclk_rises == 0, "R3 clock idle after burst", aclk_rises, 0);
  endtask

  task automatic t_restart();
    pulse_cfg();
    wait_cyc(200);
    clr_mon();
    pulse_cfg();
    wait_cyc(1100);
    chk(aclk_rises == 256, "R8 restarted burst", aclk_rises, 256);
    for (int k = 0; k < NODES; k++)
      chk(rise_t[k] - fall_t[k] == 4 * k + 6, "R8 restart hand-off",
          rise_t[k] - fall_t[k], 4 * k + 6);
    check_addrs("R8 addresses after restart");
  endtask

  task automatic t_irq();
    auto_en = 1'b1;
    @(negedge clk) plane_evt = 1'b1;
    @(negedge clk) plane_evt = 1'b0;
    wait_cyc(600);
    for (int k = 0; k < NODES; k++)
      chk(rise_t[k] - fall_t[k] == 512, "R9 interrupt width",
          rise_t[k] - fall_t[k], 512);
    check_addrs("R9 addresses kept");
  endtask

  task automatic t_ignore();
    auto_en = 1'b0;
    clr_mon();
    @(negedge clk) plane_evt = 1'b1;
    @(negedge clk) plane_evt = 1'b0;
    wait_cyc(600);
    chk(low_cnt == 0, "R10 event with auto off", low_cnt, 0);
    auto_en = 1'b1;
    pulse_cfg();
    wait_cyc(100);
    clr_mon();
    wait_cyc(200);
    @(negedge clk) plane_evt = 1'b1;
    @(negedge clk) plane_evt = 1'b0;
    wait_cyc(1400);
    chk(low_cnt == 0, "R10 event during pass", low_cnt, 0);
    auto_en = 1'b0;
  endtask

  initial begin
    for (int k = 0; k < NODES; k++) begin fall_t[k] = 0; rise_t[k] = 0; end
    t_reset();
    t_boot();
    t_trigger();
    t_restart();
    t_irq();
    t_ignore();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    wait_cyc(20000);
    nchk++;
    nfail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule